// File: doc/BRIEF.md
# Comparator Output Conditioning Router

This block sits directly after an analog comparator. It takes the comparator's one-bit decision and turns it into the final conditioned output. First it can invert the raw bit. Then it masks the bit with a blanking window taken from one of several timer compare signals. This lets a current-limit trip ignore the switching spike at the start of a PWM period.

The conditioned bit feeds three kinds of destination at the same time. It drives a pad output and a dedicated interrupt/event line. It also drives one timer input, picked from a set of candidates such as break, second break, reference clear or an input-capture channel. The whole path is combinational and uses no clock, so it keeps working while the bus clock is stopped in a low-power mode.

The analog comparator, its reference multiplexer and the pin multiplexing are outside this block.

Top module: `comp_out_router`

## Requirements
- R1: With blanking off and the block enabled, `invert_i`=0 makes `pad_o` equal `cmp_raw_i`, and `invert_i`=1 makes `pad_o` equal the inverse of `cmp_raw_i`.
- R2: A blanking select of 0 applies no mask, so `pad_o` is the polarity-adjusted bit.
- R3: A blanking select code k in 1..NUM_BLANK (1..3 by default) picks `blank_src_i[k-1]`. While that source is high (active-high window), `pad_o` is 0.
- R4: Blanking select codes above NUM_BLANK (4..7 by default) are reserved and behave exactly like code 0. Sources that are not selected have no effect.
- R5: Blanking is applied after polarity. With `invert_i`=1, `cmp_raw_i`=0 and an active selected window, `pad_o` is 0.
- R6: A route select code k in 1..NUM_DEST (1..8 by default) drives `dest_o[k-1]` with the conditioned bit and holds every other `dest_o` bit at 0.
- R7: Route select 0 and the reserved codes above NUM_DEST (9..15 by default) hold all of `dest_o` at 0.
- R8: `irq_o` and `pad_o` always equal the conditioned bit, whatever the route select, and change together with the selected `dest_o` bit.
- R9: With `en_i`=0, `pad_o`, `irq_o` and all of `dest_o` are 0 for every other input.
- R10: Outputs follow input changes with no clock edge. The path holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cmp_raw_i | input | 1 | Raw comparator decision |
| en_i | input | 1 | Block enable; 0 forces every output low |
| invert_i | input | 1 | Polarity control; 1 inverts the raw bit |
| blank_sel_i | input | BSEL_W (3) | Blanking window select; 0 is none |
| blank_src_i | input | NUM_BLANK (3) | Candidate timer compare windows, active high |
| route_sel_i | input | RSEL_W (4) | Timer destination select; 0 is none |
| pad_o | output | 1 | Conditioned bit toward the pad |
| irq_o | output | 1 | Conditioned bit toward the interrupt/event line |
| dest_o | output | NUM_DEST (8) | One-hot timer destination outputs |

## Verification
The bench sweeps every combination of the inputs. This covers the reserved blanking and routing codes, which a design with a loose decoder would treat as real selections: a mask would appear, or a stray timer input would be driven. It also checks a window that is active but not selected. A design that indexed the sources off by one would mask the output at the wrong time. A directed case with inversion and an active window catches a design that masks before inverting, because such a design would drive the output high during the window. A final stretch with the bench clock stopped catches any register placed on the path, which would leave the outputs stale.

// File: rtl/comp_cond_pkg.sv
package comp_cond_pkg;

    // Select code that means "nothing selected" for both selectors
    localparam int unsigned SEL_NONE = 0;

    // Intermediate values of the conditioning chain
    typedef struct packed {
        logic pol;    // raw bit after polarity
        logic masked; // after blanking
        logic cond;   // after enable gating
    } cond_chain_t;

endpackage

// File: rtl/comp_polarity.sv
module comp_polarity (
    input  logic raw_i,
    input  logic invert_i,
    output logic pol_o
);

    always_comb begin
        pol_o = invert_i ? ~raw_i : raw_i;
    end

endmodule

// File: rtl/comp_blank_mask.sv
module comp_blank_mask #(
    parameter int unsigned NUM_BLANK = 3,
    parameter int unsigned BSEL_W    = 3
) (
    input  logic [BSEL_W-1:0]    sel_i,
    input  logic [NUM_BLANK-1:0] src_i,
    input  logic                 din_i,
    output logic                 dout_o,
    output logic                 blank_o
);

    logic [NUM_BLANK-1:0] hit_d;

    // Code k (1..NUM_BLANK) picks src_i[k-1]; codes above that are ignored
    for (genvar k = 0; k < NUM_BLANK; k++) begin : g_hit
        always_comb begin
            hit_d[k] = (sel_i == BSEL_W'(k + 1)) & src_i[k];
        end
    end

    always_comb begin
        blank_o = |hit_d;
        dout_o  = din_i & ~blank_o;
    end

    always_comb begin
        if (blank_o) begin
            p_window_masks_r3: assert (dout_o == 1'b0)
                else $error("active window did not mask output");
        end
        if (sel_i == BSEL_W'(comp_cond_pkg::SEL_NONE)) begin
            p_no_window_r2: assert (dout_o == din_i)
                else $error("no-blank code altered the bit");
        end
    end

endmodule

// File: rtl/comp_dest_router.sv
module comp_dest_router #(
    parameter int unsigned NUM_DEST = 8,
    parameter int unsigned RSEL_W   = 4
) (
    input  logic [RSEL_W-1:0]   sel_i,
    input  logic                din_i,
    output logic [NUM_DEST-1:0] dest_o
);

    // Code k (1..NUM_DEST) drives dest_o[k-1]; others drive nothing
    for (genvar k = 0; k < NUM_DEST; k++) begin : g_dest
        always_comb begin
            dest_o[k] = din_i & (sel_i == RSEL_W'(k + 1));
        end
    end

    always_comb begin
        p_dest_onehot_r6: assert ($onehot0(dest_o))
            else $error("more than one destination driven");
        if ((sel_i == RSEL_W'(comp_cond_pkg::SEL_NONE)) ||
            (32'(sel_i) > NUM_DEST)) begin
            p_dest_idle_r7: assert (dest_o == '0)
                else $error("destination driven for idle code");
        end
    end

endmodule

// File: rtl/comp_out_router.sv
module comp_out_router #(
    parameter int unsigned NUM_BLANK = 3,
    parameter int unsigned BSEL_W    = 3,
    parameter int unsigned NUM_DEST  = 8,
    parameter int unsigned RSEL_W    = 4
) (
    input  logic                 cmp_raw_i,
    input  logic                 en_i,
    input  logic                 invert_i,
    input  logic [BSEL_W-1:0]    blank_sel_i,
    input  logic [NUM_BLANK-1:0] blank_src_i,
    input  logic [RSEL_W-1:0]    route_sel_i,
    output logic                 pad_o,
    output logic                 irq_o,
    output logic [NUM_DEST-1:0]  dest_o
);

    import comp_cond_pkg::*;

    localparam int unsigned BSEL_CODES = 1 << BSEL_W;
    localparam int unsigned RSEL_CODES = 1 << RSEL_W;

    if (NUM_BLANK >= BSEL_CODES || NUM_DEST >= RSEL_CODES) begin : g_bad_cfg
        initial $error("select field too narrow for candidate count");
    end

    cond_chain_t chain_d;
    logic        pol_w;
    logic        masked_w;
    logic        blank_w;

    comp_polarity u_pol (
        .raw_i    (cmp_raw_i),
        .invert_i (invert_i),
        .pol_o    (pol_w)
    );

    comp_blank_mask #(
        .NUM_BLANK (NUM_BLANK),
        .BSEL_W    (BSEL_W)
    ) u_blank (
        .sel_i   (blank_sel_i),
        .src_i   (blank_src_i),
        .din_i   (pol_w),
        .dout_o  (masked_w),
        .blank_o (blank_w)
    );

    always_comb begin
        chain_d.pol    = pol_w;
        chain_d.masked = masked_w;
        chain_d.cond   = en_i & masked_w;
    end

    comp_dest_router #(
        .NUM_DEST (NUM_DEST),
        .RSEL_W   (RSEL_W)
    ) u_route (
        .sel_i  (route_sel_i),
        .din_i  (chain_d.cond),
        .dest_o (dest_o)
    );

    always_comb begin
        pad_o = chain_d.cond;
        irq_o = chain_d.cond;
    end

    always_comb begin
        if (!en_i) begin
            p_disabled_quiet_r9: assert (!pad_o && !irq_o && dest_o == '0)
                else $error("output active while disabled");
        end
        p_irq_tracks_pad_r8: assert (irq_o == pad_o)
            else $error("interrupt line differs from pad");
        if (blank_w) begin
            p_mask_after_pol_r5: assert (!pad_o)
                else $error("pad high inside blanking window");
        end
    end

endmodule

// File: tb/tb_comp_out_router.sv
module tb_comp_out_router;

    localparam int NB = 3;
    localparam int BW = 3;
    localparam int ND = 8;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          run_clk = 1'b1;
    logic          rst_n = 1'b0;
    logic          raw, en, inv;
    logic [BW-1:0] bsel;
    logic [NB-1:0] bsrc;
    logic [RW-1:0] rsel;
    logic          pad, irq;
    logic [ND-1:0] dest;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #5 if (run_clk) clk = ~clk;

    comp_out_router #(.NUM_BLANK(NB), .BSEL_W(BW), .NUM_DEST(ND), .RSEL_W(RW)) dut (
        .cmp_raw_i   (raw),
        .en_i        (en),
        .invert_i    (inv),
        .blank_sel_i (bsel),
        .blank_src_i (bsrc),
        .route_sel_i (rsel),
        .pad_o       (pad),
        .irq_o       (irq),
        .dest_o      (dest)
    );

    // Behavioural expectation from the requirements
    function automatic bit exp_cond();
        bit b = 1'b0;
        bit v;
        int s = int'(bsel);
        if (s >= 1 && s <= NB) b = bsrc[s-1];
        v = inv ? !raw : raw;
        return en && v && !b;
    endfunction

    function automatic logic [ND-1:0] exp_dest();
        logic [ND-1:0] d = '0;
        int s = int'(rsel);
        if (s >= 1 && s <= ND) d[s-1] = exp_cond();
        return d;
    endfunction

    function automatic string pad_tag();
        int s = int'(bsel);
        if (!en) return "R9";
        if (s > NB) return "R4";
        if (s >= 1 && bsrc[s-1]) return "R3";
        if (s == 0) return inv ? "R1" : "R2";
        return "R1";
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [ND-1:0] act, logic [ND-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_all();
        int s = int'(rsel);
        check_bit(pad_tag(), pad, exp_cond());
        check_bit(en ? "R8" : "R9", irq, exp_cond());
        check_vec(!en ? "R9" : ((s >= 1 && s <= ND) ? "R6" : "R7"), dest, exp_dest());
    endtask

    task automatic drive(bit r, bit e, bit i, int bs, int src, int rs);
        raw  = r;
        en   = e;
        inv  = i;
        bsel = BW'(bs);
        bsrc = NB'(src);
        rsel = RW'(rs);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        drive(0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: all inputs idle, everything low (R9)
        check_bit("R9", pad, 1'b0);
        check_vec("R9", dest, '0);

        // Directed: polarity before blanking (R5)
        @(posedge clk); drive(0, 1, 1, 2, 3'b010, 1);
        @(negedge clk);
        check_bit("R5", pad, 1'b0);
        check_vec("R5", dest, '0);
        @(posedge clk); drive(0, 1, 1, 2, 3'b101, 1);
        @(negedge clk);
        check_bit("R5", pad, 1'b1);
        check_vec("R6", dest, 8'b0000_0001);

        // Exhaustive sweep, one pattern per clock
        for (int r = 0; r < 2; r++)
            for (int e = 0; e < 2; e++)
                for (int i = 0; i < 2; i++)
                    for (int bs = 0; bs < (1 << BW); bs++)
                        for (int src = 0; src < (1 << NB); src++)
                            for (int rs = 0; rs < (1 << RW); rs++) begin
                                @(posedge clk);
                                drive(r[0], e[0], i[0], bs, src, rs);
                                @(negedge clk);
                                check_all();
                            end

        // Clock stopped: outputs must still follow inputs (R10)
        run_clk = 1'b0;
        #20;
        drive(1, 1, 0, 0, 0, 5);
        #1;
        check_bit("R10", pad, 1'b1);
        check_vec("R10", dest, 8'b0001_0000);
        drive(1, 1, 0, 3, 3'b100, 5);
        #1;
        check_bit("R10", pad, 1'b0);
        check_bit("R10", irq, 1'b0);
        drive(0, 1, 1, 7, 3'b111, 8);
        #1;
        check_bit("R10", pad, 1'b1);
        check_vec("R10", dest, 8'b1000_0000);
        finish_run();
    end

    initial begin
        #3_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule